// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog: a 7-bit down-counter that must be reloaded by software within a time window. A fixed clock divider and a programmable power-of-two prescaler produce a slow tick from the bus clock. Each tick lowers the counter by one. When bit 6 of the counter, the "alive" bit, is about to clear, the block raises a one-cycle reset request. A reload that arrives too early, while the counter is still above a programmable window value, also raises a reset request. So does a reload that writes a value with the alive bit already clear.

Software works through a small register port with a combinational read. It can set an early-warning interrupt that flags the tick before the reset. Once software arms the watchdog, it cannot turn it off. A debug-halt input stops the countdown while a debugger holds the core. The block produces only the reset-request pulse and the interrupt line. The reset generator outside the block acts on them.

Register map (`reg_addr`):
- 0: control. Bits [6:0] hold the counter. Bit 7 is the arm bit.
- 1: configuration. Bits [6:0] hold the window. Bits [8:7] hold the prescaler code, which is log2 of the divide ratio. Bit 9 enables the early warning.
- 2: status. Bit 0 is the early-warning flag, which is cleared by writing 1.
- 3: reads as zero.

Top module: `win_watchdog`

## Requirements
- R1: After reset the control register reads 0x07F (disarmed, counter 0x7F), the configuration register reads 0x07F (window 0x7F, prescaler 0, warning off), the status register reads 0, and `rst_req` and `ew_irq` are low.
- R2: While armed, the counter decrements once every FIXED_DIV × 2^p bus cycles, where p is configuration bits [8:7]. Any control write restarts this tick phase.
- R3: Suppose an armed watchdog is loaded with value c and not written again. Then `rst_req` goes high for exactly one cycle, ((c & 0x3F) + 1) ticks after the load, as the counter moves from 0x40 to 0x3F.
- R4: A control write whose counter field has bit 6 clear raises `rst_req` in the next cycle if the watchdog is armed, or becomes armed by that same write.
- R5: A control write while armed and while the current counter is above the window value raises `rst_req` in the next cycle. A write at or below the window does not, and it reloads the counter.
- R6: The arm bit is sticky. Writing 0 to control bit 7 leaves the watchdog armed, and only a block reset disarms it.
- R7: With the warning enabled, the status flag sets on the tick that brings the counter to 0x40. `ew_irq` equals the flag ANDed with the enable. Writing 1 to status bit 0 clears the flag.
- R8: While `dbg_halt` is high, neither the counter nor the tick divider advances. Counting resumes from the same phase when `dbg_halt` falls.
- R9: While disarmed, the counter does not move and no control write raises `rst_req`. The written value reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low block reset |
| dbg_halt | input | 1 | Freeze countdown while the core is debug-halted |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register (combinational) |
| rst_req | output | 1 | One-cycle system reset request |
| ew_irq | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with FIXED_DIV = 4 instead of 4096. At that setting one tick takes 4 to 32 cycles, and the longest timeout (counter 0x7F, prescaler code 3) lasts 2048 cycles. This lets every prescaler code and the whole 0x40–0x7F load range be timed cycle-exactly, both in random runs and in directed cases. The short period also puts the premature-reload window, the freeze-and-resume phase, and the early-warning edge within a few hundred cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } wdg_reg_e;

  // bus cycles between two counter ticks
  function automatic int unsigned period_cycles(input int unsigned fixed_div,
                                                input int unsigned psc_log2);
    return fixed_div << psc_log2;
  endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned FIXED_DIV = 4096,
  parameter int          PSC_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int unsigned MAX_PERIOD = FIXED_DIV << ((1 << PSC_W) - 1);
  localparam int          DIV_W      = $clog2(MAX_PERIOD) + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = DIV_W'(wdg_pkg::period_cycles(FIXED_DIV, int'(psc)) - 1);
  assign tick  = run && (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (run)     div_q <= tick ? '0 : div_q + 1'b1;
  end

  // R8: a stopped divider holds its phase
  assert_div_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(div_q));

endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_arm,
  input  logic [CNT_W-1:0] window,
  input  logic             ew_ie,
  input  logic             ew_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             armed_q,
  output logic             rst_req,
  output logic             ew_flag
);
  localparam logic [CNT_W-1:0] FLOOR = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] WARN  = FLOOR + CNT_W'(1);

  logic armed_next;
  logic ev_bad_val;
  logic ev_early;
  logic ev_timeout;
  logic ev_warn;

  assign armed_next = armed_q | (ctrl_wr & wr_arm);
  assign ev_bad_val = ctrl_wr && armed_next && !wr_cnt[CNT_W-1];
  assign ev_early   = ctrl_wr && armed_q && (cnt_q > window);
  assign ev_timeout = !ctrl_wr && tick && (cnt_q == FLOOR);
  assign ev_warn    = !ctrl_wr && tick && (cnt_q == WARN) && ew_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '1;
      rst_req <= 1'b0;
      ew_flag <= 1'b0;
    end else begin
      armed_q <= armed_next;
      rst_req <= ev_bad_val | ev_early | ev_timeout;
      if (ctrl_wr)   cnt_q <= wr_cnt;
      else if (tick) cnt_q <= cnt_q - 1'b1;
      if (ev_warn)     ew_flag <= 1'b1;
      else if (ew_clr) ew_flag <= 1'b0;
    end
  end

  assert_arm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  assert_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr && cnt_q == FLOOR) |=> (rst_req && cnt_q == FLOOR - 1'b1));

  assert_bad_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (armed_q || wr_arm) && !wr_cnt[CNT_W-1]) |=> rst_req);

  assert_early_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && armed_q && cnt_q > window) |=> rst_req);

  assert_warn_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ew_flag) |-> (cnt_q == FLOOR));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !ctrl_wr) |=> ($stable(cnt_q) && !rst_req));

  assert_tick_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> armed_q);

endmodule

// File: rtl/wdg_regfile.sv
module wdg_regfile #(
  parameter int CNT_W = 7,
  parameter int PSC_W = 2,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             armed,
  input  logic             ew_flag,
  output logic [CNT_W-1:0] window,
  output logic [PSC_W-1:0] psc,
  output logic             ew_ie,
  output logic             ctrl_wr,
  output logic [CNT_W-1:0] wr_cnt,
  output logic             wr_arm,
  output logic             ew_clr,
  output logic [DW-1:0]    rdata
);
  import wdg_pkg::*;

  localparam int CFG_W = CNT_W + PSC_W + 1;

  logic cfg_wr;
  logic unused_wdata;

  assign unused_wdata = ^wdata[DW-1:CFG_W];
  assign ctrl_wr = we && (addr == REG_CTRL);
  assign cfg_wr  = we && (addr == REG_CFG);
  assign ew_clr  = we && (addr == REG_STAT) && wdata[0];
  assign wr_cnt  = wdata[CNT_W-1:0];
  assign wr_arm  = wdata[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window <= '1;
      psc    <= '0;
      ew_ie  <= 1'b0;
    end else if (cfg_wr) begin
      window <= wdata[CNT_W-1:0];
      psc    <= wdata[CNT_W+PSC_W-1:CNT_W];
      ew_ie  <= wdata[CNT_W+PSC_W];
    end
  end

  always_comb begin
    unique case (addr)
      REG_CTRL: rdata = DW'({armed, cnt});
      REG_CFG:  rdata = DW'({ew_ie, psc, window});
      REG_STAT: rdata = DW'(ew_flag);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int unsigned FIXED_DIV = 4096,
  parameter int          CNT_W     = 7,
  parameter int          DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_halt,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          rst_req,
  output logic          ew_irq
);
  localparam int PSC_W = 2;

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             ew_flag;
  logic [CNT_W-1:0] window;
  logic [PSC_W-1:0] psc;
  logic             ew_ie;
  logic             ctrl_wr;
  logic [CNT_W-1:0] wr_cnt;
  logic             wr_arm;
  logic             ew_clr;
  logic             run;
  logic             tick;

  assign run    = armed && !dbg_halt;
  assign ew_irq = ew_flag && ew_ie;

  wdg_regfile #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt), .armed(armed), .ew_flag(ew_flag),
    .window(window), .psc(psc), .ew_ie(ew_ie),
    .ctrl_wr(ctrl_wr), .wr_cnt(wr_cnt), .wr_arm(wr_arm), .ew_clr(ew_clr),
    .rdata(reg_rdata)
  );

  wdg_prescaler #(.FIXED_DIV(FIXED_DIV), .PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ctrl_wr), .psc(psc),
    .tick(tick)
  );

  wdg_downcount #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
    .wr_cnt(wr_cnt), .wr_arm(wr_arm), .window(window), .ew_ie(ew_ie),
    .ew_clr(ew_clr), .cnt_q(cnt), .armed_q(armed), .rst_req(rst_req),
    .ew_flag(ew_flag)
  );

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !ctrl_wr) |=> $stable(cnt));

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ew_clr && !tick) |=> !ew_irq);

endmodule

// File: tb/test_win_watchdog.sv
module test_win_watchdog;
  localparam int unsigned FDIV = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dbg_halt = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          rst_req;
  logic          ew_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  win_watchdog #(.FIXED_DIV(FDIV), .CNT_W(7), .DW(DW)) i_win_watchdog (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_req(rst_req), .ew_irq(ew_irq)
  );

  function automatic int bench_period(input int p);
    return int'(FDIV) * (1 << p);
  endfunction

  function automatic int bench_timeout(input int c, input int p);
    return ((c % 64) + 1) * bench_period(p);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_we = 1'b0; dbg_halt = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 2'(a); reg_wdata = DW'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 2'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic run_timeout(input string req, input int c, input int p, input int ie);
    int t, w, early;
    do_reset();
    wr(1, (ie << 9) | (p << 7) | 'h7F);
    wr(0, 'h80 | c);
    t = bench_timeout(c, p);
    w = (c % 64) * bench_period(p);
    early = 0;
    for (int i = 1; i <= t + 1; i++) begin
      @(negedge clk);
      if (i < t && rst_req) early++;
      if (i == t) chk({req, " rst pulse"}, int'(rst_req), 1);
      if (i == t + 1) chk({req, " pulse width"}, int'(rst_req), 0);
      if (w >= 2 && i == w - 1) chk({req, " R7 irq before"}, int'(ew_irq), 0);
      if (w >= 2 && i == w) chk({req, " R7 irq at 0x40"}, int'(ew_irq), ie);
    end
    chk({req, " no early rst"}, early, 0);
  endtask

  initial begin
    int v;
    int c, p, ie;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 'h07F);
    rd(1, v); chk("R1 cfg", v, 'h07F);
    rd(2, v); chk("R1 stat", v, 0);
    chk("R1 rst_req", int'(rst_req), 0);
    chk("R1 ew_irq", int'(ew_irq), 0);

    // R2 prescaler field position
    wr(1, (2 << 7) | 'h55);
    rd(1, v); chk("R2 cfg readback", v, 'h155);

    // R3 / R2 timing corners
    run_timeout("R3 min", 'h40, 0, 0);
    run_timeout("R3 max", 'h7F, 3, 1);
    run_timeout("R2 psc1", 'h45, 1, 1);

    // R4 bad value while armed, and arming with a bad value
    do_reset();
    wr(0, 'hFF);
    wr(0, 'h80 | 'h30);
    chk("R4 armed bad value", int'(rst_req), 1);
    @(negedge clk); chk("R4 single cycle", int'(rst_req), 0);
    do_reset();
    wr(0, 'h80 | 'h20);
    chk("R4 arm with bad value", int'(rst_req), 1);

    // R9 disarmed writes are harmless
    do_reset();
    wr(0, 'h10);
    chk("R9 no rst", int'(rst_req), 0);
    repeat (40) @(negedge clk);
    rd(0, v); chk("R9 counter frozen", v, 'h10);
    chk("R9 still no rst", int'(rst_req), 0);

    // R5 premature refresh, then legal refresh
    do_reset();
    wr(1, 'h50);
    wr(0, 'hFF);
    wr(0, 'hFF);
    chk("R5 premature", int'(rst_req), 1);
    do_reset();
    wr(1, 'h50);
    wr(0, 'hFF);
    repeat (200) @(negedge clk);
    rd(0, v); chk("R5 counter below window", v, 'h80 | ('h7F - 50));
    wr(0, 'hFF);
    chk("R5 in-window refresh", int'(rst_req), 0);
    rd(0, v); chk("R5 reload", v, 'hFF);

    // R6 arm bit sticky
    do_reset();
    wr(0, 'hFF);
    wr(0, 'h7F);
    chk("R6 no rst", int'(rst_req), 0);
    rd(0, v); chk("R6 still armed", v, 'hFF);

    // R7 flag and write-one-to-clear
    do_reset();
    wr(1, (1 << 9) | 'h7F);
    wr(0, 'h80 | 'h41);
    repeat (4) @(negedge clk);
    chk("R7 irq set", int'(ew_irq), 1);
    rd(2, v); chk("R7 stat set", v, 1);
    wr(2, 1);
    chk("R7 irq cleared", int'(ew_irq), 0);
    rd(2, v); chk("R7 stat cleared", v, 0);

    // R8 debug freeze
    do_reset();
    wr(0, 'hFF);
    dbg_halt = 1'b1;
    repeat (100) @(negedge clk);
    rd(0, v); chk("R8 frozen counter", v, 'hFF);
    chk("R8 no rst while halted", int'(rst_req), 0);
    dbg_halt = 1'b0;
    repeat (bench_timeout('h7F, 0) - 1) @(negedge clk);
    chk("R8 no rst before resumed timeout", int'(rst_req), 0);
    @(negedge clk);
    chk("R8 rst after resumed timeout", int'(rst_req), 1);

    // random loads and prescalers
    for (int k = 0; k < 16; k++) begin
      c  = 'h40 | int'($urandom % 64);
      p  = int'($urandom % 4);
      ie = int'($urandom % 2);
      run_timeout("R3 random", c, p, ie);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL guard R3 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule